// File: doc/BRIEF.md
# Operand Collector Unit

This block stands in front of one execution unit. It holds a small table of instructions that have been issued but not yet executed, and it gathers their source operands as they come back from a banked register file. The operands can arrive in any order and over several cycles. The issue side allocates a table entry with an opcode, a destination tag and up to three source register tags. One cycle later the block sends a read request for each source slot that the instruction needs.

Returned operands carry an entry index and a slot index, and each one is written into its place on its own. An entry becomes ready once every slot it needs is filled. When the execution unit can accept work, the oldest ready entry is sent out with its opcode, destination and operand data, and its table slot is freed. A younger entry that is complete can therefore go ahead of an older one that is still waiting. If no entry is complete, the execution unit sits idle for that cycle.

Top module: `opcol_unit`

## Requirements
- R1: After reset the table is empty: `alloc_full` is 0, `ex_valid` is 0 and `rd_req_valid` is 0.
- R2: An accepted allocation takes the lowest-numbered free entry. In the next cycle `rd_req_valid[s]` is 1 for exactly each slot `s` whose `alloc_need[s]` bit was set. Each request carries `rd_req_entry` equal to that entry and `rd_req_tag[s*TAG_W +: TAG_W]` equal to the source tag of slot `s`.
- R3: `alloc_full` is 1 exactly while all `N_ENTRIES` entries are occupied. An allocation attempted while full is dropped: no read request follows and no extra instruction is ever dispatched.
- R4: A return is ignored in each of these cases: it names a free entry, a slot that the entry does not need, a slot that has already been filled, or a slot index of `N_SRC` or more. An ignored return changes neither readiness nor the data that is later dispatched.
- R5: An entry is not dispatched until every slot it needs has been filled. An entry that needs no slots can be dispatched in the cycle after its allocation.
- R6: A dispatch sets `ex_valid` for one cycle, one cycle after the edge at which `ex_ready` was high and an entry was ready. It carries that entry's opcode and destination. Slot `s` data is in `ex_src[s*DATA_W +: DATA_W]` and holds the value returned for that slot, or 0 if the slot was not needed.
- R7: When several entries are ready, the one allocated earliest is dispatched first, whatever its index. A complete younger entry goes ahead of incomplete older ones.
- R8: A dispatched entry is freed at its dispatch edge and can be allocated again from the next cycle on.
- R9: No dispatch happens unless `ex_ready` was high at the edge. With `ex_ready` high and no complete entry, `ex_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_opcode | input | OPC_W | Opcode of the new instruction |
| alloc_dst | input | TAG_W | Destination register tag |
| alloc_need | input | N_SRC | One bit per source slot that must be collected |
| alloc_src_tags | input | N_SRC*TAG_W | Source register tags, slot s at s*TAG_W |
| alloc_full | output | 1 | No free entry; allocations are refused |
| rd_req_valid | output | N_SRC | Read request per slot, one cycle after allocation |
| rd_req_entry | output | EW | Entry that the read requests belong to |
| rd_req_tag | output | N_SRC*TAG_W | Register tag per requested slot |
| wb_valid | input | 1 | Operand return strobe |
| wb_entry | input | EW | Entry index of the returned operand |
| wb_slot | input | SW | Slot index of the returned operand |
| wb_data | input | DATA_W | Returned operand value |
| ex_ready | input | 1 | Execution unit can take an instruction this cycle |
| ex_valid | output | 1 | Dispatched instruction present |
| ex_opcode | output | OPC_W | Opcode of the dispatched instruction |
| ex_dst | output | TAG_W | Destination tag of the dispatched instruction |
| ex_src | output | N_SRC*DATA_W | Operand data, slot s at s*DATA_W |

## Verification
The assertions assume that the register-file side only returns data after the matching read request. They also assume that `rst` is held for at least one edge before any traffic. They do not assume well-formed returns, because the block must filter out stray and duplicate ones. The stimulus drives every input on the falling edge. It keeps `ex_ready` low while it builds up the table states it wants, and it deliberately sends returns to free entries, unneeded slots, already-filled slots and an out-of-range slot index, so that the filtering is exercised rather than assumed.

// File: rtl/opcol_pkg.sv
package opcol_pkg;
  localparam int DEF_ENTRIES = 4;
  localparam int DEF_SRC     = 3;
  localparam int DEF_DATA_W  = 32;
  localparam int DEF_OPC_W   = 8;
  localparam int DEF_TAG_W   = 8;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/opcol_free_pick.sv
module opcol_free_pick #(
  parameter int N  = opcol_pkg::DEF_ENTRIES,
  parameter int IW = opcol_pkg::idx_w(N)
) (
  input  logic [N-1:0]  busy,
  output logic [IW-1:0] idx,
  output logic          full
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) idx = IW'(i);
    end
  end

  assign full = &busy;
endmodule

// File: rtl/opcol_age_matrix.sv
module opcol_age_matrix #(
  parameter int N  = opcol_pkg::DEF_ENTRIES,
  parameter int IW = opcol_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [IW-1:0] alloc_idx,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          any
);
  // older[i][j] set: entry i was allocated before entry j
  logic [N-1:0] older [N];
  logic [N-1:0] blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else if (alloc_en) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (IW'(i) == alloc_idx)      older[i][j] <= 1'b0;
          else if (IW'(j) == alloc_idx) older[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    blocked = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j] && older[j][i]) blocked[i] = 1'b1;
      end
    end
    grant = req & ~blocked;
    grant_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) grant_idx = IW'(i);
    end
  end

  assign any = |req;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R7
endmodule

// File: rtl/opcol_operand_store.sv
module opcol_operand_store #(
  parameter int N_ENTRIES = opcol_pkg::DEF_ENTRIES,
  parameter int N_SRC     = opcol_pkg::DEF_SRC,
  parameter int DATA_W    = opcol_pkg::DEF_DATA_W,
  parameter int EW        = opcol_pkg::idx_w(N_ENTRIES),
  parameter int SW        = opcol_pkg::idx_w(N_SRC)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [EW-1:0]           wr_entry,
  input  logic [SW-1:0]           wr_slot,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [EW-1:0]           rd_entry,
  output logic [N_SRC*DATA_W-1:0] rd_data
);
  // one small memory per slot, synchronous write and registered read
  for (genvar s = 0; s < N_SRC; s++) begin : g_bank
    logic [DATA_W-1:0] mem [N_ENTRIES];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_slot == SW'(s)) mem[wr_entry] <= wr_data;
      if (rd_en) q <= mem[rd_entry];
    end

    assign rd_data[s*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/opcol_unit.sv
module opcol_unit #(
  parameter int N_ENTRIES = opcol_pkg::DEF_ENTRIES,
  parameter int N_SRC     = opcol_pkg::DEF_SRC,
  parameter int DATA_W    = opcol_pkg::DEF_DATA_W,
  parameter int OPC_W     = opcol_pkg::DEF_OPC_W,
  parameter int TAG_W     = opcol_pkg::DEF_TAG_W,
  parameter int EW        = opcol_pkg::idx_w(N_ENTRIES),
  parameter int SW        = opcol_pkg::idx_w(N_SRC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_valid,
  input  logic [OPC_W-1:0]        alloc_opcode,
  input  logic [TAG_W-1:0]        alloc_dst,
  input  logic [N_SRC-1:0]        alloc_need,
  input  logic [N_SRC*TAG_W-1:0]  alloc_src_tags,
  output logic                    alloc_full,
  output logic [N_SRC-1:0]        rd_req_valid,
  output logic [EW-1:0]           rd_req_entry,
  output logic [N_SRC*TAG_W-1:0]  rd_req_tag,
  input  logic                    wb_valid,
  input  logic [EW-1:0]           wb_entry,
  input  logic [SW-1:0]           wb_slot,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic                    ex_ready,
  output logic                    ex_valid,
  output logic [OPC_W-1:0]        ex_opcode,
  output logic [TAG_W-1:0]        ex_dst,
  output logic [N_SRC*DATA_W-1:0] ex_src
);
  // entry table
  logic [N_ENTRIES-1:0] valid_q;
  logic [N_SRC-1:0]     need_q [N_ENTRIES];
  logic [N_SRC-1:0]     got_q  [N_ENTRIES];
  logic [OPC_W-1:0]     opc_q  [N_ENTRIES];
  logic [TAG_W-1:0]     dst_q  [N_ENTRIES];

  logic [EW-1:0]        free_idx;
  logic                 alloc_ok;
  logic [N_ENTRIES-1:0] ready;
  logic [N_ENTRIES-1:0] grant;
  logic [EW-1:0]        grant_idx;
  logic                 any_ready;
  logic                 fire;
  logic [N_SRC-1:0]     take [N_ENTRIES];
  logic                 wb_take;
  logic [N_SRC-1:0]     ex_need_q;
  logic [N_SRC*DATA_W-1:0] store_q;

  opcol_free_pick #(.N(N_ENTRIES), .IW(EW)) u_free (
    .busy (valid_q),
    .idx  (free_idx),
    .full (alloc_full)
  );

  assign alloc_ok = alloc_valid && !alloc_full;

  // a return is taken only into an open slot of an occupied entry
  always_comb begin
    wb_take = 1'b0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      for (int s = 0; s < N_SRC; s++) begin
        take[e][s] = wb_valid && wb_entry == EW'(e) && wb_slot == SW'(s) &&
                     valid_q[e] && need_q[e][s] && !got_q[e][s];
        if (take[e][s]) wb_take = 1'b1;
      end
    end
    for (int e = 0; e < N_ENTRIES; e++) begin
      ready[e] = valid_q[e] && (&(got_q[e] | ~need_q[e]));
    end
  end

  opcol_age_matrix #(.N(N_ENTRIES), .IW(EW)) u_age (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (alloc_ok),
    .alloc_idx (free_idx),
    .req       (ready),
    .grant     (grant),
    .grant_idx (grant_idx),
    .any       (any_ready)
  );

  assign fire = ex_ready && any_ready;

  opcol_operand_store #(
    .N_ENTRIES (N_ENTRIES),
    .N_SRC     (N_SRC),
    .DATA_W    (DATA_W),
    .EW        (EW),
    .SW        (SW)
  ) u_store (
    .clk      (clk),
    .wr_en    (wb_take),
    .wr_entry (wb_entry),
    .wr_slot  (wb_slot),
    .wr_data  (wb_data),
    .rd_en    (fire),
    .rd_entry (grant_idx),
    .rd_data  (store_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int e = 0; e < N_ENTRIES; e++) begin
        need_q[e] <= '0;
        got_q[e]  <= '0;
        opc_q[e]  <= '0;
        dst_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (fire && grant[e]) valid_q[e] <= 1'b0;
        if (alloc_ok && free_idx == EW'(e)) begin
          valid_q[e] <= 1'b1;
          need_q[e]  <= alloc_need;
          got_q[e]   <= '0;
          opc_q[e]   <= alloc_opcode;
          dst_q[e]   <= alloc_dst;
        end else begin
          got_q[e] <= got_q[e] | take[e];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_valid <= '0;
      rd_req_entry <= '0;
      rd_req_tag   <= '0;
      ex_valid     <= 1'b0;
      ex_opcode    <= '0;
      ex_dst       <= '0;
      ex_need_q    <= '0;
    end else begin
      rd_req_valid <= alloc_ok ? alloc_need : '0;
      if (alloc_ok) begin
        rd_req_entry <= free_idx;
        rd_req_tag   <= alloc_src_tags;
      end
      ex_valid <= fire;
      if (fire) begin
        ex_opcode <= opc_q[grant_idx];
        ex_dst    <= dst_q[grant_idx];
        ex_need_q <= need_q[grant_idx];
      end
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_mask
    assign ex_src[s*DATA_W +: DATA_W] =
      ex_need_q[s] ? store_q[s*DATA_W +: DATA_W] : '0;
  end

  AST_REQ_AFTER_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid != '0) |-> $past(alloc_valid)); // R2
  AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_full) |=> (rd_req_valid == '0)); // R3
  AST_FREED_ON_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    fire |=> !valid_q[$past(grant_idx)]); // R8
  AST_DISPATCH_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    ex_valid |-> $past(ex_ready)); // R9
endmodule

// File: tb/opcol_unit_bench.sv
module opcol_unit_bench;
  localparam int NE = 4;
  localparam int NS = 3;
  localparam int DW = 32;
  localparam int OW = 8;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 1'b0;
  logic [OW-1:0] alloc_opcode = '0;
  logic [TW-1:0] alloc_dst = '0;
  logic [NS-1:0] alloc_need = '0;
  logic [NS*TW-1:0] alloc_src_tags = '0;
  logic alloc_full;
  logic [NS-1:0] rd_req_valid;
  logic [1:0] rd_req_entry;
  logic [NS*TW-1:0] rd_req_tag;
  logic wb_valid = 1'b0;
  logic [1:0] wb_entry = '0;
  logic [1:0] wb_slot = '0;
  logic [DW-1:0] wb_data = '0;
  logic ex_ready = 1'b0;
  logic ex_valid;
  logic [OW-1:0] ex_opcode;
  logic [TW-1:0] ex_dst;
  logic [NS*DW-1:0] ex_src;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opcol_unit u_opcol_unit (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_opcode(alloc_opcode), .alloc_dst(alloc_dst),
    .alloc_need(alloc_need), .alloc_src_tags(alloc_src_tags), .alloc_full(alloc_full),
    .rd_req_valid(rd_req_valid), .rd_req_entry(rd_req_entry), .rd_req_tag(rd_req_tag),
    .wb_valid(wb_valid), .wb_entry(wb_entry), .wb_slot(wb_slot), .wb_data(wb_data),
    .ex_ready(ex_ready), .ex_valid(ex_valid), .ex_opcode(ex_opcode), .ex_dst(ex_dst),
    .ex_src(ex_src)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic alloc(input logic [7:0] op, input logic [7:0] dst, input logic [2:0] need,
                       input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] t2);
    alloc_valid = 1'b1;
    alloc_opcode = op;
    alloc_dst = dst;
    alloc_need = need;
    alloc_src_tags = {t2, t1, t0};
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic ret(input logic [1:0] e, input logic [1:0] s, input logic [31:0] d);
    wb_valid = 1'b1;
    wb_entry = e;
    wb_slot = s;
    wb_data = d;
    step();
    wb_valid = 1'b0;
  endtask

  task automatic chk_req(input string req, input logic [2:0] v, input logic [1:0] e,
                         input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] t2);
    chk(req, "rd_req_valid", 64'(rd_req_valid), 64'(v));
    if (v != 3'b000) chk(req, "rd_req_entry", 64'(rd_req_entry), 64'(e));
    if (v[0]) chk(req, "tag0", 64'(rd_req_tag[0*TW +: TW]), 64'(t0));
    if (v[1]) chk(req, "tag1", 64'(rd_req_tag[1*TW +: TW]), 64'(t1));
    if (v[2]) chk(req, "tag2", 64'(rd_req_tag[2*TW +: TW]), 64'(t2));
  endtask

  task automatic chk_ex(input string req, input logic v, input logic [7:0] op,
                        input logic [7:0] dst, input logic [31:0] d0,
                        input logic [31:0] d1, input logic [31:0] d2);
    chk(req, "ex_valid", 64'(ex_valid), 64'(v));
    if (v) begin
      chk(req, "ex_opcode", 64'(ex_opcode), 64'(op));
      chk(req, "ex_dst", 64'(ex_dst), 64'(dst));
      chk(req, "src0", 64'(ex_src[0*DW +: DW]), 64'(d0));
      chk(req, "src1", 64'(ex_src[1*DW +: DW]), 64'(d1));
      chk(req, "src2", 64'(ex_src[2*DW +: DW]), 64'(d2));
    end
  endtask

  task automatic t_reset();
    chk("R1", "alloc_full", 64'(alloc_full), 64'd0);
    chk("R1", "ex_valid", 64'(ex_valid), 64'd0);
    chk("R1", "rd_req_valid", 64'(rd_req_valid), 64'd0);
  endtask

  task automatic t_basic();
    ex_ready = 1'b1;
    alloc(8'h11, 8'h05, 3'b111, 8'h01, 8'h02, 8'h03);
    chk_req("R2", 3'b111, 2'd0, 8'h01, 8'h02, 8'h03);
    ret(2'd0, 2'd2, 32'hA2);
    chk_ex("R5", 1'b0, 0, 0, 0, 0, 0);
    ret(2'd0, 2'd0, 32'hA0);
    chk_ex("R5", 1'b0, 0, 0, 0, 0, 0);
    ret(2'd0, 2'd1, 32'hA1);
    chk_ex("R5", 1'b0, 0, 0, 0, 0, 0);
    step();
    chk_ex("R6", 1'b1, 8'h11, 8'h05, 32'hA0, 32'hA1, 32'hA2);
    step();
    chk_ex("R9", 1'b0, 0, 0, 0, 0, 0);
    ex_ready = 1'b0;
  endtask

  task automatic t_masked();
    ex_ready = 1'b1;
    alloc(8'h22, 8'h07, 3'b010, 8'h00, 8'h09, 8'h00);
    chk_req("R8", 3'b010, 2'd0, 8'h00, 8'h09, 8'h00);
    ret(2'd0, 2'd1, 32'hBEEF);
    chk_ex("R5", 1'b0, 0, 0, 0, 0, 0);
    step();
    chk_ex("R6", 1'b1, 8'h22, 8'h07, 32'h0, 32'hBEEF, 32'h0);
    alloc(8'h33, 8'h08, 3'b000, 8'h00, 8'h00, 8'h00);
    chk_req("R2", 3'b000, 2'd0, 0, 0, 0);
    chk_ex("R5", 1'b0, 0, 0, 0, 0, 0);
    step();
    chk_ex("R5", 1'b1, 8'h33, 8'h08, 32'h0, 32'h0, 32'h0);
    ex_ready = 1'b0;
    step();
  endtask

  task automatic t_order();
    alloc(8'h41, 8'h11, 3'b001, 8'h21, 0, 0);
    alloc(8'h42, 8'h12, 3'b001, 8'h22, 0, 0);
    chk_req("R2", 3'b001, 2'd1, 8'h22, 0, 0);
    alloc(8'h43, 8'h13, 3'b001, 8'h23, 0, 0);
    ret(2'd1, 2'd0, 32'hB1);
    ret(2'd2, 2'd0, 32'hB2);
    ex_ready = 1'b1;
    step();
    chk_ex("R7", 1'b1, 8'h42, 8'h12, 32'hB1, 0, 0);
    step();
    chk_ex("R7", 1'b1, 8'h43, 8'h13, 32'hB2, 0, 0);
    ret(2'd0, 2'd0, 32'hB0);
    chk_ex("R9", 1'b0, 0, 0, 0, 0, 0);
    step();
    chk_ex("R7", 1'b1, 8'h41, 8'h11, 32'hB0, 0, 0);
    ex_ready = 1'b0;
    // entry 1 becomes older than a reused entry 0
    alloc(8'h51, 8'h31, 3'b001, 8'h31, 0, 0);
    alloc(8'h52, 8'h32, 3'b001, 8'h32, 0, 0);
    ret(2'd0, 2'd0, 32'hC0);
    ex_ready = 1'b1;
    step();
    chk_ex("R6", 1'b1, 8'h51, 8'h31, 32'hC0, 0, 0);
    ex_ready = 1'b0;
    alloc(8'h53, 8'h33, 3'b001, 8'h33, 0, 0);
    chk_req("R8", 3'b001, 2'd0, 8'h33, 0, 0);
    ret(2'd0, 2'd0, 32'hC2);
    ret(2'd1, 2'd0, 32'hC1);
    ex_ready = 1'b1;
    step();
    chk_ex("R7", 1'b1, 8'h52, 8'h32, 32'hC1, 0, 0);
    step();
    chk_ex("R7", 1'b1, 8'h53, 8'h33, 32'hC2, 0, 0);
    step();
    chk_ex("R9", 1'b0, 0, 0, 0, 0, 0);
    ex_ready = 1'b0;
  endtask

  task automatic t_full();
    for (int i = 0; i < NE; i++) begin
      chk("R3", "alloc_full before fill", 64'(alloc_full), 64'd0);
      alloc(8'(8'h60 + i), 8'(i), 3'b001, 8'(8'h40 + i), 0, 0);
      chk_req("R2", 3'b001, 2'(i), 8'(8'h40 + i), 0, 0);
    end
    chk("R3", "alloc_full", 64'(alloc_full), 64'd1);
    alloc(8'h6F, 8'h0F, 3'b111, 8'h4F, 8'h4F, 8'h4F);
    chk_req("R3", 3'b000, 2'd0, 0, 0, 0);
    for (int i = 0; i < NE; i++) ret(2'(i), 2'd0, 32'(32'hD0 + i));
    ex_ready = 1'b1;
    for (int i = 0; i < NE; i++) begin
      step();
      chk_ex("R3", 1'b1, 8'(8'h60 + i), 8'(i), 32'(32'hD0 + i), 0, 0);
    end
    step();
    chk_ex("R3", 1'b0, 0, 0, 0, 0, 0);
    chk("R3", "alloc_full after drain", 64'(alloc_full), 64'd0);
    ex_ready = 1'b0;
  endtask

  task automatic t_ignore();
    ret(2'd1, 2'd0, 32'hDEAD);
    alloc(8'h44, 8'h01, 3'b011, 8'h04, 8'h05, 8'h00);
    alloc(8'h55, 8'h02, 3'b001, 8'h06, 8'h00, 8'h00);
    chk_req("R2", 3'b001, 2'd1, 8'h06, 0, 0);
    ret(2'd0, 2'd0, 32'hE0);
    ret(2'd0, 2'd0, 32'hBAD0);
    ret(2'd0, 2'd2, 32'hBAD2);
    ret(2'd0, 2'd3, 32'hBAD3);
    ex_ready = 1'b1;
    step();
    chk_ex("R4", 1'b0, 0, 0, 0, 0, 0);
    ret(2'd0, 2'd1, 32'hE1);
    chk_ex("R4", 1'b0, 0, 0, 0, 0, 0);
    step();
    chk_ex("R4", 1'b1, 8'h44, 8'h01, 32'hE0, 32'hE1, 32'h0);
    ex_ready = 1'b0;
    ret(2'd1, 2'd0, 32'hE5);
    chk_ex("R9", 1'b0, 0, 0, 0, 0, 0);
    step();
    chk_ex("R9", 1'b0, 0, 0, 0, 0, 0);
    ex_ready = 1'b1;
    step();
    chk_ex("R4", 1'b1, 8'h55, 8'h02, 32'hE5, 0, 0);
    ex_ready = 1'b0;
    step();
    chk_ex("R8", 1'b0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_masked();
    t_order();
    t_full();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule